// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block holds in-flight instructions in a circular buffer so that they can finish execution in any order and still change architectural state in program order. At issue the block takes an entry, reports its index as the result tag for the reservation station, and records the operation kind, the destination register or memory address and, for stores, the data if it is already known. Results come back on a broadcast result bus with a tag. A waiting entry takes the value and becomes ready.

Each cycle the oldest entry leaves the buffer if it is ready. A register operation drives a register-file write. A store drives a memory write. A branch whose result says it was predicted correctly leaves with no other effect. A mispredicted branch raises a flush pulse with the correct target. That pulse discards every entry, clears the rename map and, outside this block, the reservation stations. The block then spends one recovery cycle before issue opens again at tag 0. The block also keeps a rename map naming the youngest uncommitted writer of each register. Issue-time operand lookups therefore read pending values from the buffer instead of the register file.

Control is an occupancy state machine with four states. EMPTY means no entry is held. PARTIAL means some but not all entries are held. FULL means all DEPTH entries are held. RECOVER is the single cycle after a flush. Its transitions are:
- flush_taken: any state goes to RECOVER when a mispredicted branch commits.
- recover_done: RECOVER goes to EMPTY.
- fill: EMPTY goes to PARTIAL, or PARTIAL goes to FULL, when the next occupancy is nonzero or reaches DEPTH.
- drain: FULL goes to PARTIAL, or PARTIAL goes to EMPTY, when entries leave.
- hold: the state does not change when occupancy is unchanged.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `iss_ready` is 1, `iss_tag` is 0, and `rf_we`, `mem_we` and `flush` are 0.
- R2: The `iss_kind` encoding is 0 for a register op, 1 for a store, 2 for a branch, and 3 is reserved.
  - An issue is accepted in a cycle where `iss_valid` and `iss_ready` are both 1.
  - `iss_tag` names the entry taken. Successive accepted issues get consecutive tags modulo DEPTH.
  - `iss_ready` is 0 while DEPTH entries are held. An issue offered then is ignored and leaves no trace in later lookups or commits.
- R3: A bus cycle with `cdb_valid` and the tag of a held entry stores `cdb_value` and `cdb_mispred` in that entry and marks it ready.
- R4: Entries leave in issue order, at most one per cycle, and only when the oldest is ready. A register op drives `rf_we` with `rf_waddr` set to its destination and `rf_wdata` set to its value, in the cycle it leaves.
- R5: A store leaving drives `mem_we` with its issue address and data.
  - The data is `iss_data` if `iss_data_ok` was set at issue. Otherwise the store waits for its bus result.
- R6: A branch whose bus result has `cdb_mispred` = 0 leaves the buffer without raising `rf_we`, `mem_we` or `flush`.
- R7: A branch whose bus result has `cdb_mispred` = 1 raises `flush` when it reaches the head, with `redirect_pc` equal to its bus value.
  - All younger entries are discarded, and an issue offered in that cycle is dropped.
  - In the next cycle `iss_ready` is 0 and nothing commits. After that, issue resumes at tag 0.
- R8: Lookup port k (register in `lk_reg` bits [k*REG_W +: REG_W]) reports `lk_busy` = 1 exactly when an uncommitted register op targets that register.
  - `lk_tag` is the youngest such entry. `lk_ready` and `lk_value` are that entry's ready bit and value.
  - An older writer committing does not clear the mapping of a younger one.
- R9: In any cycle at most one of `rf_we`, `mem_we` and `flush` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Operation kind (0 reg, 1 store, 2 branch) |
| iss_dreg | input | REG_W | Destination register of a register op |
| iss_addr | input | ADDR_W | Memory address of a store |
| iss_data_ok | input | 1 | Store data already known at issue |
| iss_data | input | DATA_W | Store data when known |
| iss_ready | output | 1 | Buffer can accept an issue |
| iss_tag | output | IDX_W | Entry index given to the issuing instruction |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | IDX_W | Entry the result belongs to |
| cdb_value | input | DATA_W | Result value, store data or branch target |
| cdb_mispred | input | 1 | Branch result: prediction was wrong |
| lk_reg | input | NLOOK*REG_W | Registers to look up |
| lk_busy | output | NLOOK | Register has a pending writer |
| lk_tag | output | NLOOK*IDX_W | Youngest pending writer |
| lk_ready | output | NLOOK | Pending writer has its value |
| lk_value | output | NLOOK*DATA_W | Pending writer's value |
| rf_we | output | 1 | Register-file write at commit |
| rf_waddr | output | REG_W | Register written |
| rf_wdata | output | DATA_W | Value written |
| mem_we | output | 1 | Memory write at commit |
| mem_addr | output | ADDR_W | Store address |
| mem_wdata | output | DATA_W | Store data |
| flush | output | 1 | Mispredicted branch committed: discard all |
| redirect_pc | output | DATA_W | Restart target while flush is high |

## Verification
The bench completes results in reverse order and checks that the head still blocks until the oldest is ready. A design that retired whatever was ready would write registers out of order. It fills the buffer and offers one extra issue. A design that counted full and empty wrongly would overwrite the oldest entry or stall early, and the ignored op would appear in a lookup. It issues two writers of the same register and lets the older one commit. A map that cleared unconditionally would then report the register as free while a younger writer is pending. It also commits a mispredicted branch with younger ready entries behind it and an issue offered in the flush cycle. A design that failed to discard those, or that skipped the recovery cycle, would commit stale results or hand out a tag other than 0.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2,
        KIND_RSVD   = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2,
        OCC_RECOVER = 2'd3
    } occ_state_e;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop,
    input  logic             flush,
    output logic             issue_open,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx
);

    occ_state_e       state, state_nxt;
    logic [PTR_W-1:0] head_ptr, tail_ptr;
    logic [PTR_W-1:0] occ, occ_nxt;
    logic             push;

    assign push    = push_req && issue_open;
    assign occ     = tail_ptr - head_ptr;
    assign occ_nxt = occ + PTR_W'(push) - PTR_W'(pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OCC_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (flush) begin
            state_nxt = OCC_RECOVER;
        end else begin
            unique case (state)
                OCC_RECOVER: state_nxt = OCC_EMPTY;
                OCC_EMPTY, OCC_PARTIAL, OCC_FULL: begin
                    if (occ_nxt == '0)                 state_nxt = OCC_EMPTY;
                    else if (occ_nxt == PTR_W'(DEPTH)) state_nxt = OCC_FULL;
                    else                               state_nxt = OCC_PARTIAL;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state)
            OCC_EMPTY, OCC_PARTIAL: issue_open = 1'b1;
            OCC_FULL, OCC_RECOVER:  issue_open = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
        end else if (flush) begin
            head_ptr <= '0;
            tail_ptr <= '0;
        end else begin
            head_ptr <= head_ptr + PTR_W'(pop);
            tail_ptr <= tail_ptr + PTR_W'(push);
        end
    end

    assign head_idx = head_ptr[IDX_W-1:0];
    assign tail_idx = tail_ptr[IDX_W-1:0];

endmodule

// File: rtl/rob_entries.sv
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  op_kind_e          alloc_kind,
    input  logic [REG_W-1:0]  alloc_reg,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic              alloc_ready,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              wb_mispred,
    input  logic              retire_en,
    input  logic [IDX_W-1:0]  retire_idx,
    output logic              busy_o [DEPTH],
    output logic              rdy_o  [DEPTH],
    output logic              mis_o  [DEPTH],
    output op_kind_e          kind_o [DEPTH],
    output logic [REG_W-1:0]  dreg_o [DEPTH],
    output logic [ADDR_W-1:0] addr_o [DEPTH],
    output logic [DATA_W-1:0] val_o  [DEPTH]
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic              busy_q, rdy_q, mis_q;
        op_kind_e          kind_q;
        logic [REG_W-1:0]  dreg_q;
        logic [ADDR_W-1:0] addr_q;
        logic [DATA_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                busy_q <= 1'b0;
                rdy_q  <= 1'b0;
                mis_q  <= 1'b0;
                kind_q <= KIND_REG;
                dreg_q <= '0;
                addr_q <= '0;
                val_q  <= '0;
            end else if (flush) begin
                busy_q <= 1'b0;
                rdy_q  <= 1'b0;
                mis_q  <= 1'b0;
            end else begin
                if (retire_en && retire_idx == IDX_W'(i)) begin
                    busy_q <= 1'b0;
                    rdy_q  <= 1'b0;
                end
                if (wb_en && wb_idx == IDX_W'(i) && busy_q) begin
                    val_q <= wb_data;
                    rdy_q <= 1'b1;
                    mis_q <= wb_mispred;
                end
                if (alloc_en && alloc_idx == IDX_W'(i)) begin
                    busy_q <= 1'b1;
                    kind_q <= alloc_kind;
                    dreg_q <= alloc_reg;
                    addr_q <= alloc_addr;
                    val_q  <= alloc_data;
                    rdy_q  <= alloc_ready;
                    mis_q  <= 1'b0;
                end
            end
        end

        assign busy_o[i] = busy_q;
        assign rdy_o[i]  = rdy_q;
        assign mis_o[i]  = mis_q;
        assign kind_o[i] = kind_q;
        assign dreg_o[i] = dreg_q;
        assign addr_o[i] = addr_q;
        assign val_o[i]  = val_q;
    end

endmodule

// File: rtl/rob_regmap.sv
module rob_regmap #(
    parameter int NREG  = 16,
    parameter int DEPTH = 8,
    localparam int REG_W = $clog2(NREG),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [IDX_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    input  logic [IDX_W-1:0] clr_tag,
    output logic             map_vld [NREG],
    output logic [IDX_W-1:0] map_tag [NREG]
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic             vld_q;
        logic [IDX_W-1:0] tag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                tag_q <= '0;
            end else if (flush) begin
                vld_q <= 1'b0;
            end else if (set_en && set_reg == REG_W'(r)) begin
                vld_q <= 1'b1;
                tag_q <= set_tag;
            end else if (clr_en && clr_reg == REG_W'(r) && tag_q == clr_tag) begin
                vld_q <= 1'b0;
            end
        end

        assign map_vld[r] = vld_q;
        assign map_tag[r] = tag_q;
    end

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int NLOOK  = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_valid,
    input  logic [1:0]              iss_kind,
    input  logic [REG_W-1:0]        iss_dreg,
    input  logic [ADDR_W-1:0]       iss_addr,
    input  logic                    iss_data_ok,
    input  logic [DATA_W-1:0]       iss_data,
    output logic                    iss_ready,
    output logic [IDX_W-1:0]        iss_tag,
    input  logic                    cdb_valid,
    input  logic [IDX_W-1:0]        cdb_tag,
    input  logic [DATA_W-1:0]       cdb_value,
    input  logic                    cdb_mispred,
    input  logic [NLOOK*REG_W-1:0]  lk_reg,
    output logic [NLOOK-1:0]        lk_busy,
    output logic [NLOOK*IDX_W-1:0]  lk_tag,
    output logic [NLOOK-1:0]        lk_ready,
    output logic [NLOOK*DATA_W-1:0] lk_value,
    output logic                    rf_we,
    output logic [REG_W-1:0]        rf_waddr,
    output logic [DATA_W-1:0]       rf_wdata,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    flush,
    output logic [DATA_W-1:0]       redirect_pc
);

    op_kind_e         new_kind;
    logic             accept, commit_go;
    logic [IDX_W-1:0] head_idx, tail_idx;

    logic              e_busy [DEPTH];
    logic              e_rdy  [DEPTH];
    logic              e_mis  [DEPTH];
    op_kind_e          e_kind [DEPTH];
    logic [REG_W-1:0]  e_dreg [DEPTH];
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [DATA_W-1:0] e_val  [DEPTH];

    logic             map_vld [NREG];
    logic [IDX_W-1:0] map_tag [NREG];

    logic              h_busy, h_rdy, h_mis;
    op_kind_e          h_kind;
    logic [REG_W-1:0]  h_dreg;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_val;

    assign new_kind = op_kind_e'(iss_kind);
    assign accept   = iss_valid && iss_ready;
    assign iss_tag  = tail_idx;

    rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (iss_valid),
        .pop        (commit_go),
        .flush      (flush),
        .issue_open (iss_ready),
        .head_idx   (head_idx),
        .tail_idx   (tail_idx)
    );

    rob_entries #(
        .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_entries (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .alloc_en    (accept),
        .alloc_idx   (tail_idx),
        .alloc_kind  (new_kind),
        .alloc_reg   (iss_dreg),
        .alloc_addr  (iss_addr),
        .alloc_data  (iss_data),
        .alloc_ready (new_kind == KIND_STORE && iss_data_ok),
        .wb_en       (cdb_valid),
        .wb_idx      (cdb_tag),
        .wb_data     (cdb_value),
        .wb_mispred  (cdb_mispred),
        .retire_en   (commit_go),
        .retire_idx  (head_idx),
        .busy_o      (e_busy),
        .rdy_o       (e_rdy),
        .mis_o       (e_mis),
        .kind_o      (e_kind),
        .dreg_o      (e_dreg),
        .addr_o      (e_addr),
        .val_o       (e_val)
    );

    rob_regmap #(.NREG(NREG), .DEPTH(DEPTH)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .set_en  (accept && new_kind == KIND_REG),
        .set_reg (iss_dreg),
        .set_tag (tail_idx),
        .clr_en  (commit_go && h_kind == KIND_REG),
        .clr_reg (h_dreg),
        .clr_tag (head_idx),
        .map_vld (map_vld),
        .map_tag (map_tag)
    );

    // Head entry view
    assign h_busy = e_busy[head_idx];
    assign h_rdy  = e_rdy[head_idx];
    assign h_mis  = e_mis[head_idx];
    assign h_kind = e_kind[head_idx];
    assign h_dreg = e_dreg[head_idx];
    assign h_addr = e_addr[head_idx];
    assign h_val  = e_val[head_idx];

    assign commit_go = h_busy && h_rdy;

    // Commit actions, one per cycle, chosen by the kind of the head entry
    always_comb begin
        rf_we       = 1'b0;
        mem_we      = 1'b0;
        flush       = 1'b0;
        rf_waddr    = h_dreg;
        rf_wdata    = h_val;
        mem_addr    = h_addr;
        mem_wdata   = h_val;
        redirect_pc = h_val;
        if (commit_go) begin
            unique case (h_kind)
                KIND_REG:    rf_we  = 1'b1;
                KIND_STORE:  mem_we = 1'b1;
                KIND_BRANCH: flush  = h_mis;
                KIND_RSVD:   ;
            endcase
        end
    end

    // Operand lookup ports
    for (genvar g = 0; g < NLOOK; g++) begin : g_look
        logic [REG_W-1:0] lreg;
        logic [IDX_W-1:0] ltag;
        assign lreg = lk_reg[g*REG_W +: REG_W];
        assign ltag = map_tag[lreg];
        assign lk_busy[g]                  = map_vld[lreg];
        assign lk_tag[g*IDX_W +: IDX_W]    = map_vld[lreg] ? ltag : '0;
        assign lk_ready[g]                 = map_vld[lreg] && e_rdy[ltag];
        assign lk_value[g*DATA_W +: DATA_W] = map_vld[lreg] ? e_val[ltag] : '0;
    end

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [IDX_W-1:0] iss_tag,
    input logic             rf_we,
    input logic             mem_we,
    input logic             flush
);

    // R9
    one_commit_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, mem_we, flush}));

    // R7
    recover_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !iss_ready);

    // R7
    recover_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !(rf_we || mem_we || flush));

    // R7
    tag_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (iss_tag == '0));

    // R2
    tag_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && !flush) |=> (iss_tag == IDX_W'($past(iss_tag) + 1'b1)));

    // R2
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(iss_valid && iss_ready) && !flush) |=> $stable(iss_tag));

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_tag   (iss_tag),
    .rf_we     (rf_we),
    .mem_we    (mem_we),
    .flush     (flush)
);

// File: tb/rob_core_test.sv
module rob_core_test;

    localparam int DEPTH  = 8;
    localparam int NREG   = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int NLOOK  = 2;
    localparam int IDX_W  = 3;
    localparam int REG_W  = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    iss_valid = 1'b0;
    logic [1:0]              iss_kind = '0;
    logic [REG_W-1:0]        iss_dreg = '0;
    logic [ADDR_W-1:0]       iss_addr = '0;
    logic                    iss_data_ok = 1'b0;
    logic [DATA_W-1:0]       iss_data = '0;
    logic                    iss_ready;
    logic [IDX_W-1:0]        iss_tag;
    logic                    cdb_valid = 1'b0;
    logic [IDX_W-1:0]        cdb_tag = '0;
    logic [DATA_W-1:0]       cdb_value = '0;
    logic                    cdb_mispred = 1'b0;
    logic [NLOOK*REG_W-1:0]  lk_reg = '0;
    logic [NLOOK-1:0]        lk_busy;
    logic [NLOOK*IDX_W-1:0]  lk_tag;
    logic [NLOOK-1:0]        lk_ready;
    logic [NLOOK*DATA_W-1:0] lk_value;
    logic                    rf_we, mem_we, flush;
    logic [REG_W-1:0]        rf_waddr;
    logic [DATA_W-1:0]       rf_wdata, mem_wdata, redirect_pc;
    logic [ADDR_W-1:0]       mem_addr;

    always #2 clk = ~clk;

    rob_core uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dreg(iss_dreg),
        .iss_addr(iss_addr), .iss_data_ok(iss_data_ok), .iss_data(iss_data),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .cdb_mispred(cdb_mispred),
        .lk_reg(lk_reg), .lk_busy(lk_busy), .lk_tag(lk_tag),
        .lk_ready(lk_ready), .lk_value(lk_value),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .flush(flush), .redirect_pc(redirect_pc)
    );

    // Behavioural reference model: program-ordered queue of in-flight ops
    typedef struct {
        int tag; int kind; int dreg; int addr; int val; bit rdy; bit mis;
    } ment_t;
    ment_t q[$];
    int    tail = 0;
    bit    recov = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Pending stimulus for the next cycle
    bit d_iv; int d_ik, d_idr, d_iad, d_idat; bit d_iok;
    bit d_cv; int d_ct, d_cval; bit d_cm;
    int d_l0 = 0, d_l1 = 0;
    bit e_acc, e_go, e_fl;

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic iss(int k, int r, int a, bit ok, int d);
        d_iv = 1; d_ik = k; d_idr = r; d_iad = a; d_iok = ok; d_idat = d;
    endtask

    task automatic bus(int t, int v, bit m);
        d_cv = 1; d_ct = t; d_cval = v; d_cm = m;
    endtask

    task automatic look(int a, int b);
        d_l0 = a; d_l1 = b;
    endtask

    task automatic check_outputs();
        bit er;
        int hk;
        er = !recov && (q.size() < DEPTH);
        chk("R2 iss_ready", iss_ready, er);
        if (er) chk("R2 iss_tag", iss_tag, tail);
        e_acc = d_iv && er;
        e_go  = !recov && q.size() > 0 && q[0].rdy;
        hk    = (q.size() > 0) ? q[0].kind : -1;
        e_fl  = e_go && hk == 2 && q[0].mis;
        chk("R4 rf_we", rf_we, e_go && hk == 0);
        chk("R5 mem_we", mem_we, e_go && hk == 1);
        chk(e_fl ? "R7 flush" : "R6 flush", flush, e_fl);
        chk("R9 one action", $countones({rf_we, mem_we, flush}) <= 1, 1);
        if (e_go && hk == 0) begin
            chk("R4 rf_waddr", rf_waddr, q[0].dreg);
            chk("R3 R4 rf_wdata", rf_wdata, q[0].val);
        end
        if (e_go && hk == 1) begin
            chk("R5 mem_addr", mem_addr, q[0].addr);
            chk("R5 mem_wdata", mem_wdata, q[0].val);
        end
        if (e_fl) chk("R7 redirect_pc", redirect_pc, q[0].val);
        for (int p = 0; p < NLOOK; p++) begin
            int r, hit;
            r   = (p == 0) ? d_l0 : d_l1;
            hit = -1;
            for (int i = q.size() - 1; i >= 0; i--)
                if (hit < 0 && q[i].kind == 0 && q[i].dreg == r) hit = i;
            chk("R8 lk_busy", lk_busy[p], hit >= 0);
            if (hit >= 0) begin
                chk("R8 lk_tag", lk_tag[p*IDX_W +: IDX_W], q[hit].tag);
                chk("R8 lk_ready", lk_ready[p], q[hit].rdy);
                if (q[hit].rdy) chk("R8 lk_value", lk_value[p*DATA_W +: DATA_W], q[hit].val);
            end
        end
    endtask

    task automatic update_model();
        ment_t n;
        if (recov) recov = 1'b0;
        if (e_go) begin
            if (e_fl) begin
                q.delete();
                tail  = 0;
                recov = 1'b1;
                return;
            end
            void'(q.pop_front());
        end
        if (d_cv)
            foreach (q[i])
                if (q[i].tag == d_ct) begin
                    q[i].val = d_cval; q[i].rdy = 1'b1; q[i].mis = d_cm;
                end
        if (e_acc) begin
            n.tag = tail; n.kind = d_ik; n.dreg = d_idr; n.addr = d_iad;
            n.val = d_idat; n.rdy = (d_ik == 1) && d_iok; n.mis = 1'b0;
            q.push_back(n);
            tail = (tail + 1) % DEPTH;
        end
    endtask

    task automatic tick();
        @(negedge clk);
        iss_valid   = d_iv;
        iss_kind    = 2'(d_ik);
        iss_dreg    = REG_W'(d_idr);
        iss_addr    = ADDR_W'(d_iad);
        iss_data_ok = d_iok;
        iss_data    = DATA_W'(d_idat);
        cdb_valid   = d_cv;
        cdb_tag     = IDX_W'(d_ct);
        cdb_value   = DATA_W'(d_cval);
        cdb_mispred = d_cm;
        lk_reg      = {REG_W'(d_l1), REG_W'(d_l0)};
        #1;
        check_outputs();
        @(posedge clk);
        update_model();
        d_iv = 0; d_ik = 0; d_idr = 0; d_iad = 0; d_iok = 0; d_idat = 0;
        d_cv = 0; d_ct = 0; d_cval = 0; d_cm = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t0;
        d_iv = 0; d_cv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 iss_ready", iss_ready, 1);
        chk("R1 iss_tag", iss_tag, 0);
        chk("R1 rf_we", rf_we, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 flush", flush, 0);

        // R3 R4 R8: out-of-order completion, in-order commit, two writers of r3
        look(3, 5);
        iss(0, 3, 0, 0, 0); tick();
        iss(0, 5, 0, 0, 0); tick();
        iss(0, 3, 0, 0, 0); tick();
        bus(2, 222, 0); tick();
        bus(0, 100, 0); tick();
        tick();
        bus(1, 111, 0); tick();
        idle(4);

        // R5 stores: data at issue, data from the bus
        look(7, 8);
        iss(1, 0, 'h40, 1, 55); tick();
        iss(1, 0, 'h44, 0, 0); tick();
        tick();
        bus(4, 66, 0); tick();
        idle(3);

        // R6 correctly predicted branch
        iss(2, 0, 0, 0, 0); tick();
        bus(5, 'h400, 0); tick();
        idle(3);

        // R2 fill, extra issue ignored, reverse completion, wrap
        look(9, 1);
        for (int i = 0; i < DEPTH; i++) begin
            iss(0, i + 1, 0, 0, 0); tick();
        end
        iss(0, 9, 0, 0, 0); tick();
        tick();
        t0 = tail;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            bus((t0 + i) % DEPTH, 1000 + i, 0); tick();
        end
        idle(10);

        // R7 mispredicted branch with younger ready entries
        look(2, 4);
        t0 = tail;
        iss(0, 2, 0, 0, 0); tick();
        iss(2, 0, 0, 0, 0); tick();
        iss(0, 4, 0, 0, 0); tick();
        iss(0, 2, 0, 0, 0); tick();
        bus((t0 + 2) % DEPTH, 444, 0); tick();
        bus((t0 + 3) % DEPTH, 333, 0); tick();
        bus(t0, 777, 0); tick();
        tick();
        bus((t0 + 1) % DEPTH, 'h1234, 1); tick();
        iss(0, 6, 0, 0, 0); tick();      // flush cycle: issue dropped
        iss(0, 6, 0, 0, 0); tick();      // recovery cycle: not ready
        look(6, 2);
        iss(0, 6, 0, 0, 0); tick();      // restarts at tag 0
        bus(0, 9, 0); tick();
        idle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule